// File: doc/BRIEF.md
# Layered Decoder Schedule Controller

This block sequences a layered decoder for quasi-cyclic LDPC codes whose base matrix has 16 block columns, each block a 42x42 cyclic permutation. A small stored program lists, for every step, a flag that marks the first step of a block row, two block-column addresses and a rotation amount for each. The controller walks the program and issues two LLR-memory reads per step. A fixed-latency pipeline model then returns each pair as a write-back, in issue order.

A scoreboard holds one bit per block column. A bit is set when its column is read and cleared when that column is written back. A step whose columns are still in flight waits until both are free, so hazards between layers are resolved by stalling rather than by forwarding. The whole program is repeated once per iteration, up to a fixed limit. At the end of each iteration the controller samples an "all checks satisfied" input and may stop early to save energy.

Software loads the program through a simple write port while the block is idle. It sets the program length and pulses start. It then waits for done and reads the iteration and cycle counts for throughput figures.

Top module: `ldpc_layer_sched`

## Requirements
- R1: After reset, busy, done, rdValid and wrValid are low, and iterCount and cycleCount are zero.
- R2: A start pulse while idle launches decoding. The first read is issued in the cycle after start, and reads follow program order from entry 0. Each entry word is {rowStart[20], colA[19:16], rotA[15:10], colB[9:6], rotB[5:0]}, and its fields appear unchanged on the read ports.
- R3: A block column read in cycle t is not read again before cycle t+PIPE_LAT+1. A step whose columns are free issues at once, so conflict-free steps issue on consecutive cycles.
- R4: Every read pair is written back exactly PIPE_LAT cycles after its read, with the same two columns, in the same order as the reads.
- R5: One iteration issues every program entry once. When the parity input is never high at an iteration end, exactly MAX_ITER (5) iterations run, and iterCount ends at 5.
- R6: parityOk is sampled only in the cycle in which the last entry of an iteration issues. A high value there ends decoding after that iteration; a high value in any other cycle has no effect.
- R7: After the final iteration no further reads issue. done pulses for one cycle in the first cycle with no write-back outstanding, and busy is low in the cycle after.
- R8: cycleCount equals the number of cycles from the first read cycle to the done cycle, both included, stalls counted. It holds that value until the next start.
- R9: A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch decoding (accepted only when idle) |
| parityOk | input | 1 | All parity checks satisfied, sampled at iteration end |
| seqLen | input | 6 | Number of program entries used (1 to SEQ_DEPTH) |
| seqWe | input | 1 | Program write strobe (idle only) |
| seqAddr | input | 5 | Program write address |
| seqData | input | 21 | Program entry word |
| busy | output | 1 | Decoding in progress |
| done | output | 1 | One-cycle completion pulse |
| iterCount | output | 3 | Iterations completed |
| cycleCount | output | 16 | Cycles used by the last decode |
| rdValid | output | 1 | Read pair issued this cycle |
| rdRowStart | output | 1 | Issued step begins a block row |
| rdColA | output | 4 | First block column read |
| rdRotA | output | 6 | Rotation for first column |
| rdColB | output | 4 | Second block column read |
| rdRotB | output | 6 | Rotation for second column |
| wrValid | output | 1 | Write-back pair this cycle |
| wrColA | output | 4 | First block column written |
| wrColB | output | 4 | Second block column written |

## Verification
The embedded properties check the local rules on every cycle. A write-back only ever targets columns the scoreboard marks as in flight. done never coincides with a write-back, and busy drops right after done. The iteration count never decreases during a run and never passes its limit. The bench scenarios show what needs a full run to see: stall spacing when consecutive steps share a column, back-to-back issue when they do not, the exact cycle totals, and early stopping. They also show that parity pulses away from an iteration end, and a second start during a run, change nothing.

// File: rtl/ldpc_sched_pkg.sv
package ldpc_sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } schedState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic issue;
    logic active;
  } schedStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic hazard;
    logic pipeEmpty;
  } schedStatus_t;
endpackage

// File: rtl/ldpc_sched_dpath.sv
module ldpc_sched_dpath
  import ldpc_sched_pkg::*;
#(
  parameter int NUM_COLS  = 16,
  parameter int ROT_W     = 6,
  parameter int SEQ_DEPTH = 32,
  parameter int PIPE_LAT  = 4,
  localparam int COL_W    = $clog2(NUM_COLS),
  localparam int PTR_W    = $clog2(SEQ_DEPTH),
  localparam int ENTRY_W  = 1 + 2 * (COL_W + ROT_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               seqWe,
  input  logic [PTR_W-1:0]   seqAddr,
  input  logic [ENTRY_W-1:0] seqData,
  input  logic [PTR_W-1:0]   seqPtr,
  input  schedStrobe_t       strobe,
  output schedStatus_t       status,
  output logic               rdRowStart,
  output logic [COL_W-1:0]   rdColA,
  output logic [ROT_W-1:0]   rdRotA,
  output logic [COL_W-1:0]   rdColB,
  output logic [ROT_W-1:0]   rdRotB,
  output logic               wrValid,
  output logic [COL_W-1:0]   wrColA,
  output logic [COL_W-1:0]   wrColB
);
  localparam int ROT_B_LO = 0;
  localparam int COL_B_LO = ROT_W;
  localparam int ROT_A_LO = ROT_W + COL_W;
  localparam int COL_A_LO = 2 * ROT_W + COL_W;
  localparam int ROW_BIT  = ENTRY_W - 1;

  logic [ENTRY_W-1:0] seqMem [SEQ_DEPTH];
  logic [ENTRY_W-1:0] curEntry;

  always_ff @(posedge clk) begin
    if (seqWe && !strobe.active) seqMem[seqAddr] <= seqData;
  end

  assign curEntry   = seqMem[seqPtr];
  assign rdRowStart = curEntry[ROW_BIT];
  assign rdColA     = curEntry[COL_A_LO +: COL_W];
  assign rdRotA     = curEntry[ROT_A_LO +: ROT_W];
  assign rdColB     = curEntry[COL_B_LO +: COL_W];
  assign rdRotB     = curEntry[ROT_B_LO +: ROT_W];

  // scoreboard: one bit per block column in flight
  logic [NUM_COLS-1:0] sbBits, sbNext;

  always_comb begin
    sbNext = sbBits;
    if (wrValid) begin
      sbNext[wrColA] = 1'b0;
      sbNext[wrColB] = 1'b0;
    end
    if (strobe.issue) begin
      sbNext[rdColA] = 1'b1;
      sbNext[rdColB] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) sbBits <= '0;
    else       sbBits <= sbNext;
  end

  // fixed-latency pipeline model
  logic [PIPE_LAT-1:0] pipeVld;
  logic [COL_W-1:0]    pipeColA [PIPE_LAT];
  logic [COL_W-1:0]    pipeColB [PIPE_LAT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipeVld[0]  <= 1'b0;
      pipeColA[0] <= '0;
      pipeColB[0] <= '0;
    end else begin
      pipeVld[0]  <= strobe.issue;
      pipeColA[0] <= rdColA;
      pipeColB[0] <= rdColB;
    end
  end

  for (genvar gi = 1; gi < PIPE_LAT; gi++) begin : gStage
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pipeVld[gi]  <= 1'b0;
        pipeColA[gi] <= '0;
        pipeColB[gi] <= '0;
      end else begin
        pipeVld[gi]  <= pipeVld[gi-1];
        pipeColA[gi] <= pipeColA[gi-1];
        pipeColB[gi] <= pipeColB[gi-1];
      end
    end
  end

  assign wrValid = pipeVld[PIPE_LAT-1];
  assign wrColA  = pipeColA[PIPE_LAT-1];
  assign wrColB  = pipeColB[PIPE_LAT-1];

  assign status.hazard    = sbBits[rdColA] | sbBits[rdColB];
  assign status.pipeEmpty = ~|pipeVld;

  // R4: a write-back only targets columns marked in flight
  a_r4_wb_inflight: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (sbBits[wrColA] && sbBits[wrColB]));
endmodule

// File: rtl/ldpc_sched_ctrl.sv
module ldpc_sched_ctrl
  import ldpc_sched_pkg::*;
#(
  parameter int SEQ_DEPTH = 32,
  parameter int MAX_ITER  = 5,
  parameter int CYC_W     = 16,
  localparam int PTR_W    = $clog2(SEQ_DEPTH),
  localparam int LEN_W    = $clog2(SEQ_DEPTH + 1),
  localparam int ITER_W   = $clog2(MAX_ITER + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              parityOk,
  input  logic [LEN_W-1:0]  seqLen,
  input  schedStatus_t      status,
  output schedStrobe_t      strobe,
  output logic [PTR_W-1:0]  seqPtr,
  output logic              busy,
  output logic              done,
  output logic [ITER_W-1:0] iterCount,
  output logic [CYC_W-1:0]  cycleCount
);
  schedState_e       state;
  logic [LEN_W-1:0]  lenReg;
  logic              issue, lastStep, stopNow;

  assign issue    = (state == ST_RUN) && !status.hazard;
  assign lastStep = issue && (LEN_W'(seqPtr) == (lenReg - LEN_W'(1)));
  assign stopNow  = lastStep && (parityOk || (iterCount == ITER_W'(MAX_ITER - 1)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      lenReg     <= '0;
      seqPtr     <= '0;
      iterCount  <= '0;
      cycleCount <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state      <= ST_RUN;
            lenReg     <= seqLen;
            seqPtr     <= '0;
            iterCount  <= '0;
            cycleCount <= '0;
          end
        end
        ST_RUN: begin
          cycleCount <= cycleCount + CYC_W'(1);
          if (issue) begin
            if (lastStep) begin
              seqPtr    <= '0;
              iterCount <= iterCount + ITER_W'(1);
              if (stopNow) state <= ST_DRAIN;
            end else begin
              seqPtr <= seqPtr + PTR_W'(1);
            end
          end
        end
        ST_DRAIN: begin
          cycleCount <= cycleCount + CYC_W'(1);
          if (status.pipeEmpty) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (state != ST_IDLE);
  assign done          = (state == ST_DRAIN) && status.pipeEmpty;
  assign strobe.issue  = issue;
  assign strobe.active = busy;

  // R5: iteration count never passes its limit
  a_r5_iter_bound: assert property (@(posedge clk) disable iff (!rstN)
    iterCount <= ITER_W'(MAX_ITER));

  // R7: block is idle in the cycle after done
  a_r7_idle_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R9: a running decode only moves forward in iterations
  a_r9_iter_monotonic: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && busy) |-> (iterCount >= $past(iterCount)));
endmodule

// File: rtl/ldpc_layer_sched.sv
module ldpc_layer_sched
  import ldpc_sched_pkg::*;
#(
  parameter int NUM_COLS  = 16,
  parameter int ROT_W     = 6,
  parameter int SEQ_DEPTH = 32,
  parameter int PIPE_LAT  = 4,
  parameter int MAX_ITER  = 5,
  parameter int CYC_W     = 16,
  localparam int COL_W    = $clog2(NUM_COLS),
  localparam int PTR_W    = $clog2(SEQ_DEPTH),
  localparam int LEN_W    = $clog2(SEQ_DEPTH + 1),
  localparam int ITER_W   = $clog2(MAX_ITER + 1),
  localparam int ENTRY_W  = 1 + 2 * (COL_W + ROT_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               parityOk,
  input  logic [LEN_W-1:0]   seqLen,
  input  logic               seqWe,
  input  logic [PTR_W-1:0]   seqAddr,
  input  logic [ENTRY_W-1:0] seqData,
  output logic               busy,
  output logic               done,
  output logic [ITER_W-1:0]  iterCount,
  output logic [CYC_W-1:0]   cycleCount,
  output logic               rdValid,
  output logic               rdRowStart,
  output logic [COL_W-1:0]   rdColA,
  output logic [ROT_W-1:0]   rdRotA,
  output logic [COL_W-1:0]   rdColB,
  output logic [ROT_W-1:0]   rdRotB,
  output logic               wrValid,
  output logic [COL_W-1:0]   wrColA,
  output logic [COL_W-1:0]   wrColB
);
  schedStrobe_t     strobe;
  schedStatus_t     status;
  logic [PTR_W-1:0] seqPtr;

  ldpc_sched_ctrl #(
    .SEQ_DEPTH(SEQ_DEPTH), .MAX_ITER(MAX_ITER), .CYC_W(CYC_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .parityOk(parityOk),
    .seqLen(seqLen), .status(status), .strobe(strobe), .seqPtr(seqPtr),
    .busy(busy), .done(done), .iterCount(iterCount), .cycleCount(cycleCount)
  );

  ldpc_sched_dpath #(
    .NUM_COLS(NUM_COLS), .ROT_W(ROT_W), .SEQ_DEPTH(SEQ_DEPTH), .PIPE_LAT(PIPE_LAT)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .seqWe(seqWe), .seqAddr(seqAddr), .seqData(seqData),
    .seqPtr(seqPtr), .strobe(strobe), .status(status),
    .rdRowStart(rdRowStart), .rdColA(rdColA), .rdRotA(rdRotA),
    .rdColB(rdColB), .rdRotB(rdRotB),
    .wrValid(wrValid), .wrColA(wrColA), .wrColB(wrColB)
  );

  assign rdValid = strobe.issue;

  // R7: completion is only flagged with no write-back outstanding
  a_r7_done_drained: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !wrValid);
endmodule

// File: tb/ldpc_layer_sched_tb.sv
module ldpc_layer_sched_tb;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, parityOk = 1'b0, seqWe = 1'b0;
  logic [5:0]  seqLen = '0;
  logic [4:0]  seqAddr = '0;
  logic [20:0] seqData = '0;
  logic        busy, done, rdValid, rdRowStart, wrValid;
  logic [2:0]  iterCount;
  logic [15:0] cycleCount;
  logic [3:0]  rdColA, rdColB, wrColA, wrColB;
  logic [5:0]  rdRotA, rdRotB;

  always #2 clk = ~clk;

  ldpc_layer_sched u_dut (
    .clk(clk), .rstN(rstN), .start(start), .parityOk(parityOk), .seqLen(seqLen),
    .seqWe(seqWe), .seqAddr(seqAddr), .seqData(seqData), .busy(busy), .done(done),
    .iterCount(iterCount), .cycleCount(cycleCount), .rdValid(rdValid),
    .rdRowStart(rdRowStart), .rdColA(rdColA), .rdRotA(rdRotA), .rdColB(rdColB),
    .rdRotB(rdRotB), .wrValid(wrValid), .wrColA(wrColA), .wrColB(wrColB)
  );

  int nChecks = 0, nFail = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor state
  bit monOn = 0;
  int cyc, rdCnt, wrCnt, doneCnt, orderErr, hazErr, minGap, maxGap, prevRd, firstRd, doneCyc;
  int logColA [256], logColB [256], logCyc [256], logRotA [256], logRotB [256], logRow [256];
  int lastRead [16];

  task automatic monReset();
    cyc = 0; rdCnt = 0; wrCnt = 0; doneCnt = 0; orderErr = 0; hazErr = 0;
    minGap = 1000000; maxGap = 0; prevRd = -1; firstRd = -1; doneCyc = -1;
    for (int i = 0; i < 16; i++) lastRead[i] = -1000;
  endtask

  always @(negedge clk) begin
    if (monOn) begin
      if (rdValid) begin
        if (cyc - lastRead[rdColA] < P + 1) hazErr++;
        if (cyc - lastRead[rdColB] < P + 1) hazErr++;
        lastRead[rdColA] = cyc;
        lastRead[rdColB] = cyc;
        if (prevRd >= 0) begin
          if (cyc - prevRd < minGap) minGap = cyc - prevRd;
          if (cyc - prevRd > maxGap) maxGap = cyc - prevRd;
        end else firstRd = cyc;
        prevRd = cyc;
        if (rdCnt < 256) begin
          logColA[rdCnt] = rdColA; logColB[rdCnt] = rdColB; logCyc[rdCnt] = cyc;
          logRotA[rdCnt] = rdRotA; logRotB[rdCnt] = rdRotB; logRow[rdCnt] = rdRowStart;
        end
        rdCnt++;
      end
      if (wrValid) begin
        if (wrCnt >= rdCnt || wrCnt >= 256) orderErr++;
        else if (logColA[wrCnt] != wrColA || logColB[wrCnt] != wrColB ||
                 cyc - logCyc[wrCnt] != P) orderErr++;
        wrCnt++;
      end
      if (done) begin
        doneCnt++;
        doneCyc = cyc;
      end
      cyc++;
    end
  end

  task automatic writeEntry(input int a, input int row, input int ca, input int ra,
                            input int cb, input int rb);
    @(posedge clk); #1;
    seqWe = 1'b1; seqAddr = 5'(a);
    seqData = {1'(row), 4'(ca), 6'(ra), 4'(cb), 6'(rb)};
    @(posedge clk); #1;
    seqWe = 1'b0;
  endtask

  // program 0: 8 steps, columns 2k and 2k+1, no conflicts
  task automatic loadDisjoint();
    for (int k = 0; k < 8; k++)
      writeEntry(k, (k % 2 == 0) ? 1 : 0, 2 * k, (k * 5) % 42, 2 * k + 1, (k * 7 + 1) % 42);
    seqLen = 6'd8;
  endtask

  // program 1: 2 steps sharing column 1
  task automatic loadConflict();
    writeEntry(0, 1, 0, 3, 1, 9);
    writeEntry(1, 0, 1, 4, 2, 11);
    seqLen = 6'd2;
  endtask

  // parMode: 0 never high, 1 always high, 2 high except cycle 8
  task automatic runDecode(input int parMode, input bit startMid);
    int k;
    monReset();
    @(posedge clk); #1;
    start = 1'b1; monOn = 1;
    parityOk = (parMode == 1);
    k = 0;
    while (doneCnt == 0 && k < 2000) begin
      @(posedge clk); #1;
      k++;
      start = (startMid && k == 10);
      case (parMode)
        0: parityOk = 1'b0;
        1: parityOk = 1'b1;
        default: parityOk = (k != 8);
      endcase
    end
    check(doneCnt != 0, "watchdog: done never seen", k, 0);
    parityOk = 1'b0; start = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    monOn = 0;
  endtask

  task automatic tReset();
    #1;
    check(busy == 0 && done == 0, "R1 busy/done after reset", {busy, done}, 0);
    check(rdValid == 0 && wrValid == 0, "R1 rd/wr valid after reset", {rdValid, wrValid}, 0);
    check(iterCount == 0 && cycleCount == 0, "R1 counters after reset", cycleCount, 0);
  endtask

  task automatic tFull();
    loadDisjoint();
    runDecode(0, 0);
    check(firstRd == 1, "R2 first read cycle after start", firstRd, 1);
    check(logColA[3] == 6 && logColB[3] == 7, "R2 entry 3 columns", logColA[3], 6);
    check(logRotA[3] == 15 && logRotB[3] == 22, "R2 entry 3 rotations", logRotA[3], 15);
    check(logRow[3] == 0 && logRow[4] == 1, "R2 row start flags", logRow[4], 1);
    check(logColA[8] == 0, "R2 program repeats each iteration", logColA[8], 0);
    check(maxGap == 1, "R3 conflict-free steps back to back", maxGap, 1);
    check(hazErr == 0, "R3 column re-read too early", hazErr, 0);
    check(wrCnt == 40, "R4 write-back count", wrCnt, 40);
    check(orderErr == 0, "R4 write-back order and latency", orderErr, 0);
    check(rdCnt == 40, "R5 reads for full run", rdCnt, 40);
    check(iterCount == 5, "R5 iteration limit", iterCount, 5);
    check(doneCnt == 1 && doneCyc == 45, "R7 single done pulse cycle", doneCyc, 45);
    check(busy == 0, "R7 idle after done", busy, 0);
    check(cycleCount == 45, "R8 cycle total no stalls", cycleCount, 45);
  endtask

  task automatic tEarly();
    runDecode(1, 0);
    check(iterCount == 1, "R6 early stop after first iteration", iterCount, 1);
    check(rdCnt == 8, "R6 reads before early stop", rdCnt, 8);
    check(cycleCount == 13, "R8 cycle total early stop", cycleCount, 13);
  endtask

  task automatic tMidParity();
    runDecode(2, 0);
    check(iterCount == 2, "R6 parity away from iteration end ignored", iterCount, 2);
    check(cycleCount == 21, "R6 cycle total two iterations", cycleCount, 21);
  endtask

  task automatic tHazard();
    loadConflict();
    runDecode(0, 0);
    check(minGap == P + 1 && maxGap == P + 1, "R3 stall spacing on shared column", minGap, P + 1);
    check(hazErr == 0, "R3 no early re-read", hazErr, 0);
    check(rdCnt == 10 && iterCount == 5, "R5 reads with stalls", rdCnt, 10);
    check(orderErr == 0 && wrCnt == 10, "R4 write-backs with stalls", wrCnt, 10);
    check(cycleCount == 51, "R8 cycle total with stalls", cycleCount, 51);
  endtask

  task automatic tStartBusy();
    loadDisjoint();
    runDecode(0, 1);
    check(rdCnt == 40 && iterCount == 5, "R9 start while busy ignored (reads)", rdCnt, 40);
    check(cycleCount == 45 && doneCnt == 1, "R9 start while busy ignored (cycles)", cycleCount, 45);
    check(busy == 0, "R9 no relaunch after done", busy, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tReset();
    tFull();
    tEarly();
    tMidParity();
    tHazard();
    tStartBusy();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule